// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set and Clear

This block is a 32-pin general-purpose I/O port. It sits behind a simple memory-mapped register bus with word-wide read and write strobes. It keeps two registers: an output-value register that drives the pins, and an enable register that decides which pins drive. Software can replace either register with one whole-word write. It can also change individual bits through separate write-one-to-set and write-one-to-clear addresses. Single-pin changes therefore need no read-modify-write sequence, and they cannot race with another agent that touches other pins.

The pin levels come in through a two-stage synchronizer. Software reads them through an input register, whatever each pin's enable setting is. Read data is registered and returns in the cycle after the read strobe. The port drives zero on the read data bus whenever no read is in progress. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the output-value and enable registers are zero, so pin_out and pin_oe are all 0 and bus_rdata is 0.
- R2: A write to offset 0x00 replaces the whole output-value register with bus_wdata. The new value appears on pin_out after the clock edge that takes the write.
- R3: A write to offset 0x08 replaces the whole enable register. Bit i = 1 makes pin i an output (pin_oe[i] = 1), and bit i = 0 makes it an input.
- R4: A write to offset 0x40 sets each output-value bit whose bus_wdata bit is 1. All other bits keep their value.
- R5: A write to offset 0x44 clears each output-value bit whose bus_wdata bit is 1. All other bits keep their value.
- R6: A write to offset 0x48 sets the enable bits whose bus_wdata bit is 1, and a write to offset 0x4C clears them. Bits written as 0 keep their value.
- R7: A read of offset 0x04 returns pin_in after two synchronizer flops, whatever the enable setting. A pin_in value that is held stable for two clock edges before the edge that captures the read is returned exactly.
- R8: Writes to 0x04 and to any unmapped offset change no register. Reads of 0x40, 0x44, 0x48, 0x4C and of any unmapped offset return 0.
- R9: A read strobe at one clock edge puts the addressed data on bus_rdata for the following cycle. When no read was strobed at the previous edge, bus_rdata is 0.
- R10: Reads of 0x00 and 0x08 return the current output-value and enable registers. pin_out always shows the output-value register, including for pins that are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value to the pads |
| pin_oe | output | 32 | Output enable to the pads, 1 = drive |

## Verification
The assertions check every cycle that the set and clear aliases change exactly the bits written as 1 relative to the previous register value. They also check that whole-word writes load the written word, and that idle or ignored writes leave pin_out and pin_oe unchanged. On every access they check that bus_rdata is zero without a read and that the input register returns the pin level from three edges earlier. Only the bench scenarios can show the full interplay: long random mixes of loads, sets and clears compared against a bench model, read-back of each register through the bus, and reads of alias and unmapped offsets returning zero.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

  localparam int unsigned GP_ADDR_W = 8;

  localparam logic [GP_ADDR_W-1:0] OFS_OUT_VAL = 8'h00;
  localparam logic [GP_ADDR_W-1:0] OFS_IN_VAL  = 8'h04;
  localparam logic [GP_ADDR_W-1:0] OFS_ENA     = 8'h08;
  localparam logic [GP_ADDR_W-1:0] OFS_OUT_SET = 8'h40;
  localparam logic [GP_ADDR_W-1:0] OFS_OUT_CLR = 8'h44;
  localparam logic [GP_ADDR_W-1:0] OFS_ENA_SET = 8'h48;
  localparam logic [GP_ADDR_W-1:0] OFS_ENA_CLR = 8'h4C;

  // Index of each writable register inside the register array
  localparam int unsigned REG_OUT = 0;
  localparam int unsigned REG_ENA = 1;
  localparam int unsigned NUM_WREGS = 2;

  // Kind of read selected by an offset
  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_OUT  = 2'd1,
    RSEL_IN   = 2'd2,
    RSEL_ENA  = 2'd3
  } rsel_e;

  // Per-register write command produced by the decoder
  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } wcmd_t;

  function automatic rsel_e read_select(input logic [GP_ADDR_W-1:0] a);
    rsel_e s;
    unique case (a)
      OFS_OUT_VAL: s = RSEL_OUT;
      OFS_IN_VAL:  s = RSEL_IN;
      OFS_ENA:     s = RSEL_ENA;
      default:     s = RSEL_ZERO;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_wdecode.sv
module gpio_wdecode
  import gpio_atomic_pkg::*;
#(
  parameter int unsigned ADDR_W = GP_ADDR_W
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wcmd_t             cmd [NUM_WREGS]
);

  always_comb begin
    for (int r = 0; r < NUM_WREGS; r++) cmd[r] = '0;
    if (wr) begin
      unique case (addr)
        OFS_OUT_VAL: cmd[REG_OUT].load = 1'b1;
        OFS_OUT_SET: cmd[REG_OUT].set  = 1'b1;
        OFS_OUT_CLR: cmd[REG_OUT].clr  = 1'b1;
        OFS_ENA:     cmd[REG_ENA].load = 1'b1;
        OFS_ENA_SET: cmd[REG_ENA].set  = 1'b1;
        OFS_ENA_CLR: cmd[REG_ENA].clr  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg
  import gpio_atomic_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wcmd_t            cmd,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] set_mask;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] reg_d;
  logic             reg_en;

  // Next state: a load replaces the word; otherwise set then clear,
  // with clear winning where both masks hit the same bit.
  always_comb begin
    set_mask = cmd.set ? wdata : '0;
    clr_mask = cmd.clr ? wdata : '0;
    if (cmd.load) reg_d = wdata;
    else          reg_d = (q | set_mask) & ~clr_mask;
    reg_en = cmd.load | cmd.set | cmd.clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (reg_en) q <= reg_d;
  end

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_atomic_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = GP_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  // Write decode and writable registers
  wcmd_t            wcmd [NUM_WREGS];
  logic [NPINS-1:0] wreg_q [NUM_WREGS];

  gpio_wdecode #(.ADDR_W(ADDR_W)) u_wdec (
    .wr   (bus_wr),
    .addr (bus_addr),
    .cmd  (wcmd)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_WREGS; r++) begin : g_wreg
      gpio_bitreg #(.WIDTH(NPINS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .cmd   (wcmd[r]),
        .wdata (bus_wdata),
        .q     (wreg_q[r])
      );
    end
  endgenerate

  assign pin_out = wreg_q[REG_OUT];
  assign pin_oe  = wreg_q[REG_ENA];

  // Input synchronizer
  logic [NPINS-1:0] pin_in_sync;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_insync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .d_async (pin_in),
    .d_sync  (pin_in_sync)
  );

  // Registered read path
  rsel_e            rsel;
  logic [NPINS-1:0] rdata_d;
  logic [NPINS-1:0] rdata_q;

  always_comb begin
    rsel = read_select(bus_addr);
    unique case (rsel)
      RSEL_OUT: rdata_d = wreg_q[REG_OUT];
      RSEL_IN:  rdata_d = pin_in_sync;
      RSEL_ENA: rdata_d = wreg_q[REG_ENA];
      default:  rdata_d = '0;
    endcase
    if (!bus_rd) rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk
  import gpio_atomic_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = GP_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);

  // Cycles since reset release, saturating
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  logic wr_known;
  assign wr_known = (bus_addr == OFS_OUT_VAL) || (bus_addr == OFS_ENA) ||
                    (bus_addr == OFS_OUT_SET) || (bus_addr == OFS_OUT_CLR) ||
                    (bus_addr == OFS_ENA_SET) || (bus_addr == OFS_ENA_CLR);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0))
    else $error("R1 reset state");

  a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT_VAL) |=> pin_out == $past(bus_wdata))
    else $error("R2 output load");

  a_r3_ena_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENA) |=> pin_oe == $past(bus_wdata))
    else $error("R3 enable load");

  a_r4_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata)))
    else $error("R4 output set");

  a_r5_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)))
    else $error("R5 output clear");

  a_r6_ena_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENA_SET) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)))
    else $error("R6 enable set");

  a_r6_ena_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENA_CLR) |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)))
    else $error("R6 enable clear");

  a_r7_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd3 && bus_rd && bus_addr == OFS_IN_VAL) |=> bus_rdata == $past(pin_in, 3))
    else $error("R7 input read");

  a_r8_no_write_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && wr_known) |=> ($stable(pin_out) && $stable(pin_oe)))
    else $error("R8 ignored write");

  a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0)
    else $error("R9 idle read data");

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_atomic_port_tb_top.sv
module gpio_atomic_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks;
  int errors;
  bit done;

  logic [31:0] out_m;
  logic [31:0] ena_m;
  logic [31:0] in_m;

  gpio_atomic_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Bench model of the register update
  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: out_m = d;
      8'h40: out_m = out_m | d;
      8'h44: out_m = out_m & ~d;
      8'h08: ena_m = d;
      8'h48: ena_m = ena_m | d;
      8'h4C: ena_m = ena_m & ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return out_m;
      8'h04:   return in_m;
      8'h08:   return ena_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08: return "R3";
      8'h40: return "R4";
      8'h44: return "R5";
      8'h48, 8'h4C: return "R6";
      8'h04: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
    check({req_of(a), " pin_out"}, pin_out, out_m);
    check({req_of(a), " pin_oe"}, pin_oe, ena_m);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, model_read(a));
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    in_m = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned k);
    case (k % 10)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h40;
      4: return 8'h44;
      5: return 8'h48;
      6: return 8'h4C;
      7: return 8'h01;
      8: return 8'h10;
      default: return 8'hFC;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_unused;
    checks = 0; errors = 0; done = 1'b0;
    out_m = '0; ena_m = '0; in_m = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0; pin_in = '0;
    seed_unused = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pin_out after release", pin_out, 32'h0);
    do_read(8'h00, "R1 out reg");
    do_read(8'h08, "R1 ena reg");

    // Directed corner cases
    do_write(8'h00, 32'hA5A5_0F0F);
    do_read(8'h00, "R10 out readback");
    do_write(8'h40, 32'h0000_F000);
    do_write(8'h40, 32'h0);
    do_write(8'h44, 32'hFFFF_FFFF);
    do_write(8'h44, 32'h0);
    do_write(8'h08, 32'h8000_0001);
    do_write(8'h48, 32'h0000_FFFF);
    do_write(8'h4C, 32'h0000_0F01);
    do_read(8'h08, "R10 ena readback");
    do_write(8'h40, 32'h1234_5678);
    check("R10 pin_out on input pins", pin_out & ~pin_oe, out_m & ~ena_m);
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h10, 32'hFFFF_FFFF);
    do_write(8'h41, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) do_read(8'h40 + 8'(4 * i), "R8 alias read");
    do_read(8'h01, "R8 unmapped read");
    do_read(8'hFC, "R8 unmapped read");
    drive_pins(32'hDEAD_BEEF);
    do_read(8'h04, "R7 input read");
    do_write(8'h08, 32'hFFFF_FFFF);
    do_read(8'h04, "R7 input with all outputs");
    @(negedge clk);
    check("R9 rdata after read ends", bus_rdata, 32'h0);

    // Random mix against the model
    for (int n = 0; n < 600; n++) begin
      int unsigned k;
      int unsigned op;
      logic [7:0] a;
      k = $urandom;
      op = $urandom % 8;
      a = pick_addr(k);
      if (op < 4)       do_write(a, $urandom);
      else if (op < 7)  do_read(a, {req_of(a), " random read"});
      else begin
        drive_pins($urandom);
        do_read(8'h04, "R7 random input");
      end
      if (n % 50 == 0) begin
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule